// File: doc/BRIEF.md
# Hardware Barrier Synchronization Counter

This block lets a group of parallel nodes meet at a barrier without a software message exchange. A master node loads two things together: the number of nodes that must arrive and a mask naming the participating nodes. On that load the barrier flags of the participating nodes drop. Each node that finishes its work raises a one-cycle arrival request, which takes one off the shared counter. The node then polls its own flag.

When the counter reaches zero, the block raises the flags of every participating node in a single cycle, so all of them leave the barrier together. The time from the last arrival to the release is one clock, however many nodes take part. Arrivals from several nodes in the same cycle are all counted in that cycle. Arrivals from non-participants are ignored, and so are repeat arrivals from a node that has already been counted in the current phase.

Top module: `gbc_top`

## Requirements
- R1: After reset all barrier flags are 0 and the remaining count is 0.
- R2: A load with a nonzero count sets the remaining count to the loaded value and clears the flags of the nodes in the loaded mask; both are visible in the cycle after the load.
- R3: Each participating node's arrival request reduces the count by one. Requests from several participating nodes in the same cycle are all subtracted in that cycle (the count drops by the number of bits set in the eligible request vector).
- R4: When arrivals bring the count to zero, every flag in the participant mask is set in the cycle after the final arrival.
- R5: Arrival requests from nodes whose bit is 0 in the participant mask leave the count unchanged.
- R6: A second arrival from a node already counted in the current phase leaves the count unchanged.
- R7: A load with a count of zero sets the flags of all nodes in the loaded mask in the next cycle.
- R8: A load while a phase is in progress restarts the phase: the count is reloaded, any arrival in the load cycle is ignored, and the record of nodes already counted is cleared.
- R9: The flags of nodes outside the participant mask are never changed, whether by a load or by a release.
- R10: Once set, flags stay set until the next load. Arrival requests while the count is zero leave the count at zero.
- R11: If the eligible arrivals in one cycle outnumber the remaining count, the count stops at zero and the release of R4 occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Master strobe that starts a new barrier phase |
| loadCount | input | CNT_W | Number of arrivals the phase waits for |
| loadMask | input | NUM_NODES | Participant mask, bit i for node i |
| arriveReq | input | NUM_NODES | One-cycle arrival request, bit i from node i |
| barrierFlag | output | NUM_NODES | Per-node release flag, 1 = barrier passed |
| remainCount | output | CNT_W | Arrivals still awaited in this phase |

## Verification
Two pairs of events can fall in the same clock. A master load can coincide with an arrival, and several arrivals can coincide with one another, sometimes including the final one. The bench drives a load and an arrival in the same cycle and expects the reloaded count with no subtraction. It drives groups of simultaneous arrivals, mixed with repeat arrivals and non-participants, and expects the count to drop by exactly the number of eligible requests. It also drives more simultaneous arrivals than remain and expects the count to stop at zero together with the release.

// File: rtl/gbc_pkg.sv
package gbc_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadPhase;  // start a new phase from the master load
    logic loadNone;   // the loaded count is zero: release at once
    logic decApply;   // subtract the eligible arrivals this cycle
    logic relFlags;   // this cycle's arrivals finish the phase
  } gbStrobe_t;

endpackage

// File: rtl/gbc_ctrl.sv
module gbc_ctrl
  import gbc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             loadValid,
  input  logic [CNT_W-1:0] loadCount,
  input  logic [CNT_W-1:0] curCount,
  input  logic [CNT_W-1:0] effCount,
  output gbStrobe_t        strb
);

  logic phaseOpen;
  logic anyEligible;

  assign phaseOpen   = (curCount != '0);
  assign anyEligible = (effCount != '0);

  always_comb begin
    strb = '0;
    if (loadValid) begin
      // a load overrides any arrival in the same cycle
      strb.loadPhase = 1'b1;
      strb.loadNone  = (loadCount == '0);
    end else if (phaseOpen && anyEligible) begin
      strb.decApply = 1'b1;
      strb.relFlags = (effCount >= curCount);
    end
  end

endmodule

// File: rtl/gbc_datapath.sv
module gbc_datapath
  import gbc_pkg::*;
#(
  parameter int NUM_NODES = 8,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gbStrobe_t            strb,
  input  logic [CNT_W-1:0]     loadCount,
  input  logic [NUM_NODES-1:0] loadMask,
  input  logic [NUM_NODES-1:0] arriveReq,
  output logic [CNT_W-1:0]     countQ,
  output logic [NUM_NODES-1:0] partMask,
  output logic [NUM_NODES-1:0] flagQ,
  output logic [CNT_W-1:0]     effCount
);

  logic [NUM_NODES-1:0] doneMask;
  logic [NUM_NODES-1:0] eligible;

  // participating nodes not yet counted in this phase
  assign eligible = arriveReq & partMask & ~doneMask;

  // population count of the eligible arrivals
  always_comb begin
    effCount = '0;
    for (int i = 0; i < NUM_NODES; i++) begin
      effCount = effCount + CNT_W'(eligible[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= '0;
      partMask <= '0;
      doneMask <= '0;
      flagQ    <= '0;
    end else if (strb.loadPhase) begin
      countQ   <= loadCount;
      partMask <= loadMask;
      doneMask <= '0;
      flagQ    <= (flagQ & ~loadMask) | (strb.loadNone ? loadMask : '0);
    end else if (strb.decApply) begin
      doneMask <= doneMask | eligible;
      if (strb.relFlags) begin
        countQ <= '0;
        flagQ  <= flagQ | partMask;
      end else begin
        countQ <= countQ - effCount;
      end
    end
  end

endmodule

// File: rtl/gbc_top.sv
module gbc_top
  import gbc_pkg::*;
#(
  parameter int NUM_NODES = 8,
  localparam int CNT_W    = $clog2(NUM_NODES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadValid,
  input  logic [CNT_W-1:0]     loadCount,
  input  logic [NUM_NODES-1:0] loadMask,
  input  logic [NUM_NODES-1:0] arriveReq,
  output logic [NUM_NODES-1:0] barrierFlag,
  output logic [CNT_W-1:0]     remainCount
);

  gbStrobe_t            strb;
  logic [CNT_W-1:0]     effCount;
  logic [NUM_NODES-1:0] partMask;

  gbc_ctrl #(.CNT_W(CNT_W)) ctrl (
    .loadValid (loadValid),
    .loadCount (loadCount),
    .curCount  (remainCount),
    .effCount  (effCount),
    .strb      (strb)
  );

  gbc_datapath #(.NUM_NODES(NUM_NODES), .CNT_W(CNT_W)) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .loadCount (loadCount),
    .loadMask  (loadMask),
    .arriveReq (arriveReq),
    .countQ    (remainCount),
    .partMask  (partMask),
    .flagQ     (barrierFlag),
    .effCount  (effCount)
  );

endmodule

// File: rtl/gbc_checker.sv
module gbc_checker #(
  parameter int NUM_NODES = 8,
  parameter int CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 loadValid,
  input logic [CNT_W-1:0]     loadCount,
  input logic [NUM_NODES-1:0] loadMask,
  input logic [NUM_NODES-1:0] arriveReq,
  input logic [NUM_NODES-1:0] barrierFlag,
  input logic [CNT_W-1:0]     remainCount,
  input logic [NUM_NODES-1:0] partMask
);

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    loadValid && loadCount != '0 |=> (barrierFlag & $past(loadMask)) == '0 && remainCount == $past(loadCount)); // R2

  AST_ZERO_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    loadValid && loadCount == '0 |=> (barrierFlag & $past(loadMask)) == $past(loadMask)); // R7

  AST_DEC_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |=> remainCount <= $past(remainCount) &&
      (int'($past(remainCount)) - int'(remainCount)) <= $countones($past(arriveReq & partMask))); // R3

  AST_ZERO_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid && remainCount != '0 |=> remainCount != '0 || (barrierFlag & partMask) == partMask); // R4

  AST_OUTSIDE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |=> $stable(barrierFlag & ~partMask)); // R9

  AST_OUTSIDE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> ((barrierFlag ^ $past(barrierFlag)) & ~$past(loadMask)) == '0); // R9

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |=> ($past(barrierFlag) & ~barrierFlag) == '0); // R10

  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid && remainCount == '0 |=> remainCount == '0); // R10

endmodule

bind gbc_top gbc_checker #(.NUM_NODES(NUM_NODES), .CNT_W(CNT_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .loadValid   (loadValid),
  .loadCount   (loadCount),
  .loadMask    (loadMask),
  .arriveReq   (arriveReq),
  .barrierFlag (barrierFlag),
  .remainCount (remainCount),
  .partMask    (partMask)
);

// File: tb/gbc_top_test.sv
`timescale 1ns/1ps
module gbc_top_test;

  localparam int N = 8;
  localparam int W = $clog2(N + 1);

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadValid = 1'b0;
  logic [W-1:0] loadCount = '0;
  logic [N-1:0] loadMask = '0;
  logic [N-1:0] arriveReq = '0;
  logic [N-1:0] barrierFlag;
  logic [W-1:0] remainCount;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  gbc_top #(.NUM_NODES(N)) uut (
    .clk         (clk),
    .rstN        (rstN),
    .loadValid   (loadValid),
    .loadCount   (loadCount),
    .loadMask    (loadMask),
    .arriveReq   (arriveReq),
    .barrierFlag (barrierFlag),
    .remainCount (remainCount)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock edge; inputs are then driven and outputs sampled 2 ns after it
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic doLoad(input int cnt, input int mask, input int req);
    loadValid = 1'b1; loadCount = W'(cnt); loadMask = N'(mask); arriveReq = N'(req);
    step();
    loadValid = 1'b0; arriveReq = '0;
  endtask

  task automatic arrive(input int req);
    arriveReq = N'(req);
    step();
    arriveReq = '0;
  endtask

  task automatic testReset();
    check("R1 flags", int'(barrierFlag), 0);
    check("R1 count", int'(remainCount), 0);
  endtask

  task automatic testFullGroup();
    doLoad(8, 'hFF, 0);
    check("R2 count", int'(remainCount), 8);
    check("R2 flags", int'(barrierFlag), 0);
    arrive('h01);
    check("R3 single", int'(remainCount), 7);
    arrive('h01);
    check("R6 repeat", int'(remainCount), 7);
    arrive('h0E);
    check("R3 three at once", int'(remainCount), 4);
    check("R4 not yet", int'(barrierFlag), 0);
    arrive('hF1);  // node 0 repeat mixed with four new arrivals
    check("R3 R6 mixed", int'(remainCount), 0);
    check("R4 release", int'(barrierFlag), 'hFF);
    arrive('hFF);
    check("R10 count", int'(remainCount), 0);
    step(); step();
    check("R10 flags held", int'(barrierFlag), 'hFF);
  endtask

  task automatic testPartialMask();
    doLoad(3, 'hFF, 0);
    check("R2 clear all", int'(barrierFlag), 0);
    doLoad(4, 'h0F, 0);
    arrive('hF0);
    check("R5 outsider", int'(remainCount), 4);
    arrive('h03);
    check("R3 in mask", int'(remainCount), 2);
    arrive('h0C);
    check("R4 masked release", int'(barrierFlag), 'h0F);
    check("R9 outside untouched", int'(barrierFlag) & 'hF0, 0);
  endtask

  task automatic testZeroLoad();
    doLoad(0, 'h30, 0);
    check("R7 zero load", int'(barrierFlag), 'h3F);
    check("R7 count", int'(remainCount), 0);
  endtask

  task automatic testRestart();
    doLoad(5, 'hFF, 0);
    arrive('h03);
    check("R3 pre restart", int'(remainCount), 3);
    doLoad(5, 'hFF, 'h04);
    check("R8 reload, arrival dropped", int'(remainCount), 5);
    arrive('h01);
    check("R8 record cleared", int'(remainCount), 4);
    arrive('h04);
    check("R8 dropped node counts later", int'(remainCount), 3);
  endtask

  task automatic testOverrun();
    doLoad(2, 'hFF, 0);
    arrive('h07);
    check("R11 count stops", int'(remainCount), 0);
    check("R11 release", int'(barrierFlag), 'hFF);
  endtask

  initial begin
    #(200000 * 8);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    testReset();
    testFullGroup();
    testPartialMask();
    testZeroLoad();
    testRestart();
    testOverrun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule